// File: doc/BRIEF.md
# Tag-Matched Operand Wait Pool

This block holds a small set of waiting operations for one class of execution unit. An operation is issued with an opcode and two source operands. Each operand comes either as a value or as the nonzero tag of the unit that will produce it. The issue side sees one ready flag, and the tag that the next issued operation will carry. A zero source tag marks the value as already present.

Every waiting slot watches a shared result bus. A slot copies the bus data into any operand whose pending tag equals the tag on the bus. A slot with both operands present is offered to the execution unit. When several slots are ready, the one with the lowest index wins, and one slot moves per cycle, only while the unit signals ready. The outgoing operation carries its slot tag. When a result appears on the bus under a slot's own tag, that slot becomes free.

Slot tags are `TAG_BASE` up to `TAG_BASE+NUM_ST-1`. With the default parameters these are tags 1 to 4, and slot index i has tag `TAG_BASE+i`.

Top module: `rsv_pool`

## Requirements
- R1: After reset every slot is free: `iss_ready` is 1, `iss_tag` equals `TAG_BASE`, and `disp_valid` is 0.
- R2: An issue with `iss_valid` high and `iss_ready` high goes into the lowest-index free slot. `iss_tag` shows that slot's tag, `TAG_BASE`+index, in the cycle before the accepting edge.
- R3: When no slot is free, `iss_ready` is 0 and an issue request is ignored. No slot is taken and nothing extra is later dispatched.
- R4: A source tag of 0 means the value is valid. An operation issued with both tags 0 is offered on `disp_valid` in the cycle after the accepting edge.
- R5: A waiting operand whose tag equals `bc_tag` while `bc_valid` is high takes `bc_data` at that edge. Its tag becomes 0.
- R6: If the bus matches an operand tag in the same cycle that operand is issued, the bus data is stored as the operand value and the operand counts as ready.
- R7: A broadcast whose tag matches no pending operand changes no operand. A waiting slot stays unoffered.
- R8: Among the offered slots, the lowest index is presented. It stays presented while `fu_ready` is 0. At most one slot leaves per cycle, at an edge where `disp_valid` and `fu_ready` are both 1.
- R9: A dispatch carries the slot's opcode, both operand values and the slot tag, and a slot is dispatched only once.
- R10: After a slot has been dispatched, a broadcast carrying that slot's tag frees it. The slot is offered for issue from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode to hold |
| iss_a_tag | input | TAG_W | Producer tag of first operand, 0 = value valid |
| iss_a_val | input | DATA_W | First operand value |
| iss_b_tag | input | TAG_W | Producer tag of second operand, 0 = value valid |
| iss_b_val | input | DATA_W | Second operand value |
| iss_ready | output | 1 | A slot is free |
| iss_tag | output | TAG_W | Tag the next issued operation receives |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | TAG_W | Tag of the producer of the result |
| bc_data | input | DATA_W | Result value |
| fu_ready | input | 1 | Execution unit accepts an operation |
| disp_valid | output | 1 | An operation is offered |
| disp_op | output | OP_W | Offered opcode |
| disp_a | output | DATA_W | Offered first operand |
| disp_b | output | DATA_W | Offered second operand |
| disp_tag | output | TAG_W | Tag of the offered slot |

## Verification
The issue-side outputs are combinational from slot state. A broadcast or issue at one edge therefore shows on `iss_ready`, `iss_tag` and `disp_*` in the cycle that follows, so the bench samples every output at the falling edge after the stimulus edge. A scoreboard pops the expected operation at each falling edge where `disp_valid` and `fu_ready` are both high. Each expected item is queued before the edge that makes its slot ready, so the order and the contents of the dispatches, including values captured from the bus, are compared one by one. Stall, priority and free checks are direct comparisons at the same falling edges.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  // control state of one waiting slot
  typedef struct packed {
    logic busy;   // slot holds an operation
    logic sent;   // operation has left for the execution unit
  } slot_ctl_t;
endpackage

// File: rtl/rsp_first.sv
// lowest-index selector over a request vector
module rsp_first #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsp_slot.sv
module rsp_slot
  import rsp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              take_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [TAG_W-1:0]  qa_i,
  input  logic [DATA_W-1:0] va_i,
  input  logic [TAG_W-1:0]  qb_i,
  input  logic [DATA_W-1:0] vb_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              busy_o,
  output logic              elig_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] va_o,
  output logic [DATA_W-1:0] vb_o
);
  slot_ctl_t         ctl_q, ctl_d;
  logic [TAG_W-1:0]  qa_q, qa_d, qb_q, qb_d;
  logic [DATA_W-1:0] va_q, va_d, vb_q, vb_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic              hit_a, hit_b, own_hit, upd_en;

  assign hit_a   = bc_valid_i && (qa_q != '0) && (bc_tag_i == qa_q);
  assign hit_b   = bc_valid_i && (qb_q != '0) && (bc_tag_i == qb_q);
  assign own_hit = bc_valid_i && (bc_tag_i == MY_TAG);
  assign upd_en  = alloc_i | ctl_q.busy;

  always_comb begin
    ctl_d = ctl_q;
    qa_d  = qa_q;
    qb_d  = qb_q;
    va_d  = va_q;
    vb_d  = vb_q;
    op_d  = op_q;
    if (alloc_i) begin
      ctl_d.busy = 1'b1;
      ctl_d.sent = 1'b0;
      op_d = op_i;
      qa_d = qa_i;
      va_d = va_i;
      qb_d = qb_i;
      vb_d = vb_i;
    end else if (ctl_q.busy) begin
      if (hit_a) begin
        qa_d = '0;
        va_d = bc_data_i;
      end
      if (hit_b) begin
        qb_d = '0;
        vb_d = bc_data_i;
      end
      if (take_i) ctl_d.sent = 1'b1;
      if (ctl_q.sent && own_hit) ctl_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      qa_q  <= '0;
      qb_q  <= '0;
    end else if (upd_en) begin
      ctl_q <= ctl_d;
      qa_q  <= qa_d;
      qb_q  <= qb_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      op_q <= op_d;
      va_q <= va_d;
      vb_q <= vb_d;
    end
  end

  assign busy_o = ctl_q.busy;
  assign elig_o = ctl_q.busy && !ctl_q.sent && (qa_q == '0) && (qb_q == '0);
  assign op_o   = op_q;
  assign va_o   = va_q;
  assign vb_o   = vb_q;

  // R3
  issue_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !ctl_q.busy);
  // R5
  capture_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.busy && !alloc_i && hit_a) |=> (qa_q == '0) && (va_q == $past(bc_data_i)));
  // R5
  capture_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.busy && !alloc_i && hit_b) |=> (qb_q == '0) && (vb_q == $past(bc_data_i)));
  // R9
  no_redispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !elig_o);
  // R10
  free_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.busy && ctl_q.sent && own_hit) |=> !busy_o);
endmodule

// File: rtl/rsv_pool.sv
module rsv_pool #(
  parameter int NUM_ST   = 4,
  parameter int DATA_W   = 64,
  parameter int OP_W     = 4,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              fu_ready,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag
);
  localparam int IDX_W = (NUM_ST > 1) ? $clog2(NUM_ST) : 1;

  logic [NUM_ST-1:0] busy_v, elig_v, free_gnt, disp_gnt, alloc_v, take_v;
  logic [IDX_W-1:0]  free_idx, disp_idx;
  logic [OP_W-1:0]   op_arr [NUM_ST];
  logic [DATA_W-1:0] va_arr [NUM_ST];
  logic [DATA_W-1:0] vb_arr [NUM_ST];

  // same-cycle bus capture at issue
  logic              a_hit, b_hit;
  logic [TAG_W-1:0]  a_tag_fix, b_tag_fix;
  logic [DATA_W-1:0] a_val_fix, b_val_fix;

  assign a_hit     = bc_valid && (iss_a_tag != '0) && (bc_tag == iss_a_tag);
  assign b_hit     = bc_valid && (iss_b_tag != '0) && (bc_tag == iss_b_tag);
  assign a_tag_fix = a_hit ? '0 : iss_a_tag;
  assign b_tag_fix = b_hit ? '0 : iss_b_tag;
  assign a_val_fix = a_hit ? bc_data : iss_a_val;
  assign b_val_fix = b_hit ? bc_data : iss_b_val;

  rsp_first #(.N(NUM_ST)) u_free (
    .req (~busy_v),
    .gnt (free_gnt),
    .any (iss_ready),
    .idx (free_idx)
  );

  rsp_first #(.N(NUM_ST)) u_pick (
    .req (elig_v),
    .gnt (disp_gnt),
    .any (disp_valid),
    .idx (disp_idx)
  );

  assign alloc_v = free_gnt & {NUM_ST{iss_valid}};
  assign take_v  = disp_gnt & {NUM_ST{fu_ready}};

  for (genvar g = 0; g < NUM_ST; g++) begin : g_slot
    rsp_slot #(
      .DATA_W (DATA_W),
      .OP_W   (OP_W),
      .TAG_W  (TAG_W),
      .MY_TAG (TAG_W'(TAG_BASE + g))
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (alloc_v[g]),
      .take_i     (take_v[g]),
      .op_i       (iss_op),
      .qa_i       (a_tag_fix),
      .va_i       (a_val_fix),
      .qb_i       (b_tag_fix),
      .vb_i       (b_val_fix),
      .bc_valid_i (bc_valid),
      .bc_tag_i   (bc_tag),
      .bc_data_i  (bc_data),
      .busy_o     (busy_v[g]),
      .elig_o     (elig_v[g]),
      .op_o       (op_arr[g]),
      .va_o       (va_arr[g]),
      .vb_o       (vb_arr[g])
    );
  end

  assign iss_tag  = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
  assign disp_tag = TAG_W'(TAG_BASE) + TAG_W'(disp_idx);
  assign disp_op  = op_arr[disp_idx];
  assign disp_a   = va_arr[disp_idx];
  assign disp_b   = vb_arr[disp_idx];

  // R8
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !fu_ready) |=> disp_valid);
  // R8
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_v));
endmodule

// File: tb/rsv_pool_tb.sv
module rsv_pool_tb;
  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid, bc_valid, fu_ready;
  logic [3:0]  iss_op, iss_a_tag, iss_b_tag, bc_tag;
  logic [63:0] iss_a_val, iss_b_val, bc_data;
  logic iss_ready, disp_valid;
  logic [3:0]  iss_tag, disp_op, disp_tag;
  logic [63:0] disp_a, disp_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  rsv_pool u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .fu_ready(fu_ready),
    .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input item_t it, input string req);
    exp_q.push_back(it);
    req_q.push_back(req);
  endtask

  // drive one issue, optionally with a broadcast in the same cycle
  task automatic issue(input logic [3:0] op, input logic [3:0] ta, input logic [63:0] va,
                       input logic [3:0] tb, input logic [63:0] vb, input int exp_tag,
                       input logic bv, input logic [3:0] bt, input logic [63:0] bd);
    iss_valid = 1'b1; iss_op = op;
    iss_a_tag = ta; iss_a_val = va; iss_b_tag = tb; iss_b_val = vb;
    bc_valid = bv; bc_tag = bt; bc_data = bd;
    #1;
    if (exp_tag > 0) check("R2 issue tag", 64'(iss_tag), 64'(exp_tag));
    @(posedge clk); #1;
    iss_valid = 1'b0; bc_valid = 1'b0;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [63:0] d);
    bc_valid = 1'b1; bc_tag = t; bc_data = d;
    @(posedge clk); #1;
    bc_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && disp_valid && fu_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 unexpected dispatch: actual tag %0h op %0h expected none", disp_tag, disp_op);
      end else begin
        item_t e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check({r, " op"},  64'(disp_op),  64'(e.op));
        check({r, " a"},   disp_a,        e.a);
        check({r, " b"},   disp_b,        e.b);
        check({r, " tag"}, 64'(disp_tag), 64'(e.tag));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; bc_valid = 1'b0; fu_ready = 1'b0;
    iss_op = '0; iss_a_tag = '0; iss_b_tag = '0; bc_tag = '0;
    iss_a_val = '0; iss_b_val = '0; bc_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 iss_ready", 64'(iss_ready), 64'd1);
    check("R1 iss_tag", 64'(iss_tag), 64'd1);
    check("R1 disp_valid", 64'(disp_valid), 64'd0);

    // fill all four slots with the unit held off
    issue(4'd3, 4'd0, 64'h11, 4'd0, 64'h22, 1, 1'b0, 4'd0, 64'd0);
    @(negedge clk);
    check("R4 offered after ready issue", 64'(disp_valid), 64'd1);
    check("R4 offered tag", 64'(disp_tag), 64'd1);
    issue(4'd5, 4'd0, 64'h33, 4'd0, 64'h44, 2, 1'b0, 4'd0, 64'd0);
    issue(4'd6, 4'd9, 64'hDEAD, 4'd0, 64'h55, 3, 1'b0, 4'd0, 64'd0);
    issue(4'd7, 4'd10, 64'hDEAD, 4'd11, 64'hBAD, 4, 1'b0, 4'd0, 64'd0);
    @(negedge clk);
    check("R3 full pool not ready", 64'(iss_ready), 64'd0);

    // stalled issue must be dropped
    issue(4'd9, 4'd0, 64'h66, 4'd0, 64'h77, 0, 1'b0, 4'd0, 64'd0);
    @(negedge clk);
    check("R3 still not ready", 64'(iss_ready), 64'd0);
    check("R8 lowest index held while unit busy", 64'(disp_tag), 64'd1);

    // broadcast that matches nothing
    bcast(4'd12, 64'hFFFF);

    push('{op:4'd3, a:64'h11, b:64'h22, tag:4'd1}, "R9 dispatch A");
    push('{op:4'd5, a:64'h33, b:64'h44, tag:4'd2}, "R8 dispatch B");
    fu_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check("R7 waiting slots not offered", 64'(disp_valid), 64'd0);

    push('{op:4'd6, a:64'hC0FFEE, b:64'h55, tag:4'd3}, "R5 capture C");
    bcast(4'd9, 64'hC0FFEE);
    @(negedge clk);

    // result of slot 1 frees it
    bcast(4'd1, 64'hAAAA);
    @(negedge clk);
    check("R10 freed slot ready", 64'(iss_ready), 64'd1);
    check("R10 freed slot tag", 64'(iss_tag), 64'd1);

    push('{op:4'd2, a:64'hBEEF, b:64'h99, tag:4'd1}, "R6 capture at issue");
    issue(4'd2, 4'd10, 64'h0BAD, 4'd0, 64'h99, 1, 1'b1, 4'd10, 64'hBEEF);
    @(negedge clk);

    push('{op:4'd7, a:64'hBEEF, b:64'h1234, tag:4'd4}, "R5 capture D both");
    bcast(4'd11, 64'h1234);
    @(negedge clk);
    @(negedge clk);
    check("R9 nothing left to offer", 64'(disp_valid), 64'd0);

    bcast(4'd2, 64'h1);
    bcast(4'd3, 64'h2);
    bcast(4'd4, 64'h3);
    bcast(4'd1, 64'h4);
    @(negedge clk);
    check("R10 all free ready", 64'(iss_ready), 64'd1);
    check("R10 all free tag", 64'(iss_tag), 64'd1);
    check("R9 all expected dispatches seen", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule